// File: doc/BRIEF.md
# Bit-Serial Exclusive-Minimum Check Node

This block is the check-node processor of an iterative message-passing decoder for low-density parity-check codes. Each of its edges carries one variable-to-check message at a time. A message is a quantized log-likelihood ratio in sign-magnitude form. It moves serially, one bit per clock: the sign comes first, then the magnitude from most to least significant bit. All edges are bit-aligned, and a slot-start strobe marks the sign cycle of every message.

For every edge the node returns a check-to-variable message in the same serial form. The outgoing sign is the XOR of the signs on all the other edges. The outgoing magnitude is the smallest magnitude among all the other edges. Each edge finds this exclusive minimum on the fly with a set of "still tied with the running minimum" flags over the other edges. The flags are narrowed one magnitude bit per cycle, so no word-wide comparator is needed. Every output bit is registered and appears one cycle after the input bit it depends on.

The XOR of all incoming signs is also held as a parity-fail flag. A decoder uses this flag to tell whether all parity constraints look satisfied. An enable input freezes the node: while it is low the outputs read zero and no state changes.

Top module: `bit_serial_check_node`

## Requirements
- R1: While reset is asserted, and until the first enabled clock edge after it, every output bit and the parity-fail flag are 0.
- R2: Each output bit is due exactly one enabled clock cycle after the input cycle it is formed from, with no gap between bits of a message.
- R3: In the cycle after an enabled slot-start cycle, output bit k equals the XOR of the sign inputs of every edge other than k.
- R4: In the magnitude cycles that follow, edge k carries the minimum of the other edges' magnitudes, most significant bit first. For a 4-bit message that is 3 magnitude bits.
- R5: When the smallest magnitude appears on two or more edges, every edge, including those edges, receives that smallest value.
- R6: When the smallest magnitude appears on exactly one edge, that edge receives the second-smallest magnitude and every other edge receives the smallest.
- R7: From the cycle after an enabled slot-start cycle, the parity-fail output holds the XOR of all incoming signs of that slot. It holds this value until the next enabled slot start.
- R8: While the enable input is low, all outputs read 0. Inputs, including the slot-start strobe, are ignored, and a message paused partway through continues unchanged once the enable returns.
- R9: A slot-start strobe restarts the minimum search at any point, even when a previous message was cut short. The new slot's results are not affected by the bits seen before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Node enable; low freezes state and zeroes the outputs |
| slot_start | input | 1 | High in the sign cycle of every message |
| v2c_bits | input | DEGREE | Current serial bit of the incoming message on each edge |
| c2v_bits | output | DEGREE | Current serial bit of the outgoing message on each edge |
| parity_fail | output | 1 | XOR of all incoming signs of the latest slot |

## Verification
Every outgoing bit is due one enabled cycle after its input bit: the sign one cycle after the slot-start cycle, and magnitude bit j one cycle after input magnitude bit j. The parity flag becomes valid in the same cycle as the outgoing sign and holds until the next enabled slot start. The bench drives inputs on the falling edge. It compares each output vector on the next falling edge against values computed from the message words it has stored, so each check falls exactly one register stage after its stimulus. During enable-low pauses it checks for zeros on every cycle, then resumes the same message, so any corruption of the frozen state shows up in the bits that follow.

// File: rtl/cn_bitserial_pkg.sv
package cn_bitserial_pkg;
   // default edge count of a check node and bits per serial message
   localparam int unsigned CN_DEF_DEGREE = 15;
   localparam int unsigned CN_DEF_MSG_W  = 4;
endpackage

// File: rtl/cn_sign_tree.sv
module cn_sign_tree #(
   parameter int unsigned DEGREE = 15
) (
   input  logic [DEGREE-1:0] sign_in,
   output logic [DEGREE-1:0] sign_excl,
   output logic              sign_all
);
   // a single reduction tree; removing an edge's own sign from the total
   // gives the exclusive parity for that edge
   always_comb begin
      sign_all  = ^sign_in;
      sign_excl = sign_in ^ {DEGREE{sign_all}};
   end
endmodule

// File: rtl/cn_excl_min_lane.sv
module cn_excl_min_lane #(
   parameter int unsigned DEGREE = 15,
   parameter int unsigned LANE   = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              slot_start,
   input  logic [DEGREE-1:0] bits_in,
   output logic              min_bit
);
   localparam logic [DEGREE-1:0] SELF_MASK   = {{(DEGREE-1){1'b0}}, 1'b1} << LANE;
   localparam logic [DEGREE-1:0] OTHERS_MASK = ~SELF_MASK;

   // tied[i] = edge i still equals the running exclusive minimum prefix
   logic [DEGREE-1:0] tied_q;

   // prefix bit is 0 as soon as any still-tied other edge shows a 0
   always_comb min_bit = &(~tied_q | bits_in);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tied_q <= OTHERS_MASK;
      end else if (en) begin
         if (slot_start) begin
            tied_q <= OTHERS_MASK;
         end else begin
            tied_q <= tied_q & ~(bits_in ^ {DEGREE{min_bit}});
         end
      end
   end
endmodule

// File: rtl/bit_serial_check_node.sv
module bit_serial_check_node
   import cn_bitserial_pkg::*;
#(
   parameter int unsigned DEGREE = CN_DEF_DEGREE,
   parameter int unsigned MSG_W  = CN_DEF_MSG_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              slot_start,
   input  logic [DEGREE-1:0] v2c_bits,
   output logic [DEGREE-1:0] c2v_bits,
   output logic              parity_fail
);
   localparam int unsigned MAG_W = MSG_W - 1;

   if (DEGREE < 2) begin : g_bad_degree
      $error("check node needs at least two edges");
   end
   if (MAG_W < 1) begin : g_bad_width
      $error("message must hold a sign and at least one magnitude bit");
   end

   logic [DEGREE-1:0] sign_excl;
   logic              sign_all;
   logic [DEGREE-1:0] mag_bit;
   logic [DEGREE-1:0] out_d;
   logic [DEGREE-1:0] out_q;
   logic              par_q;

   cn_sign_tree #(.DEGREE(DEGREE)) u_sign (
      .sign_in  (v2c_bits),
      .sign_excl(sign_excl),
      .sign_all (sign_all)
   );

   for (genvar k = 0; k < DEGREE; k++) begin : g_lane
      cn_excl_min_lane #(.DEGREE(DEGREE), .LANE(k)) u_lane (
         .clk       (clk),
         .rst_n     (rst_n),
         .en        (en),
         .slot_start(slot_start),
         .bits_in   (v2c_bits),
         .min_bit   (mag_bit[k])
      );
   end

   always_comb out_d = slot_start ? sign_excl : mag_bit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_q <= '0;
         par_q <= 1'b0;
      end else if (en) begin
         out_q <= out_d;
         if (slot_start) par_q <= sign_all;
      end
   end

   always_comb begin
      c2v_bits    = out_q & {DEGREE{en}};
      parity_fail = par_q & en;
   end
endmodule

// File: rtl/cn_checker.sv
module cn_checker #(
   parameter int unsigned DEGREE = 15
) (
   input logic              clk,
   input logic              rst_n,
   input logic              en,
   input logic              slot_start,
   input logic [DEGREE-1:0] v2c_bits,
   input logic [DEGREE-1:0] c2v_bits,
   input logic              parity_fail
);
   // R8: idle node shows nothing
   a_r8_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !en |-> (c2v_bits == '0 && !parity_fail));

   // R3: exclusive sign one cycle after the sign cycle
   a_r3_sign_excl: assert property (@(posedge clk) disable iff (!rst_n)
      (en && slot_start) |=>
         (!en || c2v_bits == $past(v2c_bits ^ {DEGREE{^v2c_bits}})));

   // R7: overall parity flag after the sign cycle
   a_r7_parity: assert property (@(posedge clk) disable iff (!rst_n)
      (en && slot_start) |=> (!en || parity_fail == $past(^v2c_bits)));

   // R4: all-ones magnitude column yields all-ones minimum column
   a_r4_ones_col: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !slot_start && (&v2c_bits)) |=> (!en || (&c2v_bits)));

   // R4: all-zero magnitude column yields all-zero minimum column
   a_r4_zero_col: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !slot_start && v2c_bits == '0) |=> (!en || c2v_bits == '0));
endmodule

bind bit_serial_check_node cn_checker #(.DEGREE(DEGREE)) u_cn_checker (
   .clk        (clk),
   .rst_n      (rst_n),
   .en         (en),
   .slot_start (slot_start),
   .v2c_bits   (v2c_bits),
   .c2v_bits   (c2v_bits),
   .parity_fail(parity_fail)
);

// File: tb/bit_serial_check_node_tb.sv
module bit_serial_check_node_tb_top;
   localparam int D    = 15;
   localparam int MAGW = 3;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic         rst_n, en, slot_start;
   logic [D-1:0] v2c;
   logic [D-1:0] c2v;
   logic         parity_fail;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   logic [MAGW-1:0] mag [D];
   logic [D-1:0]    sgn;

   bit_serial_check_node #(.DEGREE(D), .MSG_W(MAGW+1)) dut_i (
      .clk(clk), .rst_n(rst_n), .en(en), .slot_start(slot_start),
      .v2c_bits(v2c), .c2v_bits(c2v), .parity_fail(parity_fail)
   );

   function automatic logic [MAGW-1:0] excl_min(int k);
      logic [MAGW-1:0] m = '1;
      for (int i = 0; i < D; i++)
         if (i != k && mag[i] < m) m = mag[i];
      return m;
   endfunction

   function automatic logic [D-1:0] expect_bit(int j);
      logic [D-1:0] e;
      for (int k = 0; k < D; k++) begin
         logic [MAGW-1:0] m;
         m = excl_min(k);
         e[k] = (j == 0) ? (sgn[k] ^ (^sgn)) : m[MAGW-j];
      end
      return e;
   endfunction

   function automatic logic [D-1:0] input_bit(int j);
      logic [D-1:0] b;
      for (int i = 0; i < D; i++) b[i] = (j == 0) ? sgn[i] : mag[i][MAGW-j];
      return b;
   endfunction

   task automatic check_vec(string req, logic [D-1:0] act, logic [D-1:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic check_bit(string req, logic act, logic exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %b expected %b", req, act, exp);
      end
   endtask

   // one full message slot; optional enable-low pause after bit pause_at
   task automatic run_slot(string req, int pause_at, int pause_len);
      for (int j = 0; j <= MAGW; j++) begin
         en         = 1'b1;
         slot_start = (j == 0);
         v2c        = input_bit(j);
         @(negedge clk);
         check_vec((j == 0) ? "R3 sign (R2 timing)" : req, c2v, expect_bit(j));
         check_bit("R7 parity", parity_fail, ^sgn);
         if (j == pause_at) begin
            for (int p = 0; p < pause_len; p++) begin
               en         = 1'b0;
               slot_start = 1'($urandom);
               v2c        = D'($urandom);
               @(negedge clk);
               check_vec("R8 idle outputs", c2v, '0);
               check_bit("R8 idle parity", parity_fail, 1'b0);
            end
         end
      end
   endtask

   task automatic rand_msgs();
      for (int i = 0; i < D; i++) mag[i] = MAGW'($urandom);
      sgn = D'($urandom);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      rst_n = 1'b0; en = 1'b1; slot_start = 1'b0; v2c = '0;
      @(negedge clk);
      check_vec("R1 reset outputs", c2v, '0);
      check_bit("R1 reset parity", parity_fail, 1'b0);
      @(negedge clk);
      rst_n = 1'b1;
      check_vec("R1 after release", c2v, '0);

      // directed: all zero magnitudes, all maximum magnitudes
      for (int i = 0; i < D; i++) mag[i] = '0;
      sgn = '0;
      run_slot("R4 zero mags", -1, 0);
      for (int i = 0; i < D; i++) mag[i] = '1;
      sgn = '1;
      run_slot("R4 max mags", -1, 0);

      // R5: tie at the minimum
      for (int i = 0; i < D; i++) mag[i] = 3'd5;
      mag[2] = 3'd1; mag[11] = 3'd1; sgn = D'(15'h0A53);
      run_slot("R5 tied minimum", -1, 0);

      // R6: unique minimum gets the second minimum
      for (int i = 0; i < D; i++) mag[i] = 3'd6;
      mag[3] = 3'd0; mag[9] = 3'd2; sgn = D'(15'h0001);
      run_slot("R6 unique minimum", -1, 0);

      // R8: pause mid-message, garbage and strobes while disabled
      rand_msgs();
      run_slot("R8 resume after pause", 1, 3);
      rand_msgs();
      run_slot("R8 resume after pause", 2, 2);

      // R9: aborted message then realigned slot
      for (int r = 0; r < 4; r++) begin
         en = 1'b1; slot_start = 1'b1; v2c = D'($urandom);
         @(negedge clk);
         slot_start = 1'b0; v2c = D'($urandom);
         @(negedge clk);
         rand_msgs();
         run_slot("R9 realigned slot", -1, 0);
      end

      // random traffic, back to back (R2, R4)
      for (int n = 0; n < 60; n++) begin
         rand_msgs();
         run_slot("R4 random exclusive min", -1, 0);
      end

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule